// File: doc/BRIEF.md
# Gated Multi-Source System Reset Sequencer

This block drives the one global reset of the system. Three things can cause that reset: power-on, a front-panel push button, and a request line from the chipset logic. The chipset line lets the system reset itself after an error or when software asks for it. After power-on, the reset is held for a fixed power-up delay. It then stays held while the programmable logic receives its configuration, and it is let go only once the loader reports success. If a board strap says that no configuration is to be loaded, the power-up delay alone is enough.

The button and the chipset request have no effect until the system has reached its running state. Once it is running, either one forces a reset pulse of at least a minimum length, and the pulse lasts for as long as the source is held. The button passes through a synchronizer and a debouncer before it is acted on. A configuration error, or a configuration that does not finish within a timeout, parks the block with reset held and a fault flag raised. Only a new power-on clears that state.

Internally the block steps through four phases: power-up delay, configuration wait, running, and reset pulse. Only the running phase looks at the two secondary sources.

Top module: `sysrst_gate`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1 and `cfg_fault_o` is 0; a power-on also clears an earlier fault.
- R2: Counting the first rising edge with `por_i` low as edge 1, `sys_rst_o` stays 1 through at least edge POR_CYCLES. It can first go low after edge POR_CYCLES, and only when the strap is set.
- R3: With `load_off_i` = 0, reset is released after the first edge, from edge POR_CYCLES+1 onward, at which `cfg_done_i` = 1 and `cfg_err_i` = 0 are sampled. A `cfg_done_i` seen during the power-up delay has no effect.
- R4: `cfg_err_i` = 1 sampled during the configuration wait sets `cfg_fault_o` at that edge and keeps reset asserted until power-on. An error wins over a done seen at the same edge, and a later done is ignored.
- R5: If no done and no error arrive, `cfg_fault_o` rises after edge POR_CYCLES+CFG_TIMEOUT. A done sampled at that very edge still releases reset and raises no fault.
- R6: With `load_off_i` = 1, reset is released after edge POR_CYCLES, and `cfg_done_i` and `cfg_err_i` are ignored (the fault flag stays 0).
- R7: The button and the chipset request are ignored during the power-up delay and the configuration wait. A source pressed and released before reset is released causes no later reset pulse.
- R8: In the running state, a one-cycle `chip_req_i` sampled at edge E sets `sys_rst_o` after edge E and holds it for exactly MIN_PULSE cycles.
- R9: `button_i` (active high) is acted on only after it has been stable for DEB_CYCLES clocks past a 2-stage synchronizer. A press held from edge 1 raises reset after edge DEB_CYCLES+3 and not before, and a press shorter than DEB_CYCLES clocks causes no reset.
- R10: A source still held when the minimum pulse ends extends the reset. For `chip_req_i` held at edges 1..N (N > MIN_PULSE), reset is high after edges 1..N and low after edge N+1.
- R11: After a reset pulse the block returns to running with `cfg_fault_o` = 0, and it accepts a new request with the same MIN_PULSE timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| cfg_done_i | input | 1 | Configuration loader reports success (level) |
| cfg_err_i | input | 1 | Configuration loader reports an error (level) |
| load_off_i | input | 1 | Strap: no configuration load, skip the wait |
| button_i | input | 1 | Raw front-panel reset button, active high, asynchronous |
| chip_req_i | input | 1 | Reset request from chipset logic, active high |
| sys_rst_o | output | 1 | Global system reset, active high, registered |
| cfg_fault_o | output | 1 | Configuration failed or timed out; reset is parked |

## Verification
A wrong phase shows up at once as a reset released too early or too late. The bench measures the exact edge at which `sys_rst_o` first falls after power-on for each combination of strap, done timing and error timing, so a phase that is entered or left one cycle off is visible as a one-cycle shift. A wrong pulse counter shows as a pulse width other than MIN_PULSE within one pulse. A debouncer that lets the button through too early, or lets a glitch through, shows as a reset rising at the wrong edge or rising at all. A lost fault state shows as a release after an error or timeout, within a few cycles of the done input going high.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    // Sequencer phases; only SEQ_ACTIVE lets reset go low
    typedef enum logic [1:0] {
        SEQ_POWERUP = 2'd0,
        SEQ_LOADING = 2'd1,
        SEQ_ACTIVE  = 2'd2,
        SEQ_HOLD    = 2'd3
    } seq_state_e;

    // Status from the configuration loader and board strap
    typedef struct packed {
        logic done;
        logic err;
        logic load_off;
    } cfg_status_t;

    // Secondary reset sources after conditioning
    typedef struct packed {
        logic button;
        logic chip_req;
    } rst_src_t;

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Bits needed to hold 0 .. n-1
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic logic src_any(rst_src_t s);
        return s.button | s.chip_req;
    endfunction

endpackage

// File: rtl/sysrst_counter.sv
module sysrst_counter #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + WIDTH'(1);
        end
    end

    assign cnt_o = cnt_q;

    // Clear wins over increment: a cleared counter reads zero next cycle
    a_r11_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/sysrst_debounce.sv
module sysrst_debounce
    import sysrst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYCLES  = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;
    localparam int unsigned CW = cnt_width(DEB_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    logic [SW-1:0] sync_q;
    logic          synced;
    logic          level_q;
    logic [CW-1:0] cnt_q;

    generate
        if (SW == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= raw_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) sync_q <= '0;
                else       sync_q <= {sync_q[SW-2:0], raw_i};
            end
        end
    endgenerate

    assign synced = sync_q[SW-1];

    // Level follows the synchronized input only after DEB_CYCLES of disagreement
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
        end else if (synced == level_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            level_q <= synced;
            cnt_q   <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign level_o = level_q;

    // R9: the debounced level moves only after a full stable window
    a_r9_settled_change: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(level_q) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/sysrst_fsm.sv
module sysrst_fsm
    import sysrst_pkg::*;
#(
    parameter int unsigned POR_CYCLES  = 16,
    parameter int unsigned CFG_TIMEOUT = 40,
    parameter int unsigned MIN_PULSE   = 12
) (
    input  logic        clk_i,
    input  logic        por_i,
    input  cfg_status_t cfg_i,
    input  rst_src_t    src_i,
    output logic        rst_o,
    output logic        fault_o
);
    localparam int unsigned CW = cnt_width(max_of3(POR_CYCLES, CFG_TIMEOUT, MIN_PULSE));
    localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES - 1);
    localparam logic [CW-1:0] TO_LAST  = CW'(CFG_TIMEOUT - 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(MIN_PULSE - 1);

    seq_state_e    state_q, state_d;
    logic          fault_q, fault_d;
    logic          rst_q;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    logic          any_src;

    assign any_src = src_any(src_i);

    sysrst_counter #(.WIDTH(CW)) u_cnt (
        .clk_i (clk_i),
        .rst_i (por_i),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            SEQ_POWERUP: begin
                if (cnt == POR_LAST) begin
                    cnt_clr = 1'b1;
                    state_d = cfg_i.load_off ? SEQ_ACTIVE : SEQ_LOADING;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            SEQ_LOADING: begin
                if (fault_q) begin
                    state_d = SEQ_LOADING;      // parked until power-on
                end else if (cfg_i.err) begin
                    fault_d = 1'b1;
                end else if (cfg_i.done) begin
                    cnt_clr = 1'b1;
                    state_d = SEQ_ACTIVE;
                end else if (cnt == TO_LAST) begin
                    fault_d = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            SEQ_ACTIVE: begin
                if (any_src) begin
                    cnt_clr = 1'b1;
                    state_d = SEQ_HOLD;
                end
            end
            SEQ_HOLD: begin
                if (cnt != MIN_LAST) begin
                    cnt_inc = 1'b1;
                end else if (!any_src) begin
                    state_d = SEQ_ACTIVE;
                end
            end
            default: state_d = SEQ_POWERUP;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            state_q <= SEQ_POWERUP;
            fault_q <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
            rst_q   <= (state_d != SEQ_ACTIVE);
        end
    end

    assign rst_o   = rst_q;
    assign fault_o = fault_q;

    // R3: the running state is reached from the wait only on a clean done
    a_r3_release_needs_done: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_ACTIVE && $past(state_q) == SEQ_LOADING)
            |-> ($past(cfg_i.done) && !$past(cfg_i.err)));

    // R4: a fault never clears without power-on and keeps reset asserted
    a_r4_fault_sticky: assert property (@(posedge clk_i) disable iff (por_i)
        $past(fault_q) |-> (fault_q && rst_q && state_q == SEQ_LOADING));

    // R5: the load wait counter never passes the timeout
    a_r5_timeout_bound: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_LOADING) |-> (cnt <= TO_LAST));

    // R6: with the strap set the wait phase is never entered
    a_r6_strap_skips_wait: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_POWERUP && cfg_i.load_off) |=> (state_q != SEQ_LOADING));

    // R7: a pulse is only ever entered from the running state
    a_r7_pulse_from_run: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_HOLD) |-> ($past(state_q) == SEQ_HOLD || $past(state_q) == SEQ_ACTIVE));

    // R8: the pulse is not cut short
    a_r8_min_pulse: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_HOLD && cnt < MIN_LAST) |=> (state_q == SEQ_HOLD && rst_q));

    // R10: a held request keeps the reset asserted
    a_r10_held_request: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == SEQ_HOLD && src_i.chip_req) |=> rst_q);

endmodule

// File: rtl/sysrst_gate.sv
module sysrst_gate
    import sysrst_pkg::*;
#(
    parameter int unsigned POR_CYCLES  = 16,
    parameter int unsigned CFG_TIMEOUT = 40,
    parameter int unsigned MIN_PULSE   = 12,
    parameter int unsigned DEB_CYCLES  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic cfg_done_i,
    input  logic cfg_err_i,
    input  logic load_off_i,
    input  logic button_i,
    input  logic chip_req_i,
    output logic sys_rst_o,
    output logic cfg_fault_o
);
    cfg_status_t cfg;
    rst_src_t    src;
    logic        button_level;

    sysrst_debounce #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_CYCLES  (DEB_CYCLES)
    ) u_button (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .raw_i   (button_i),
        .level_o (button_level)
    );

    always_comb begin
        cfg.done     = cfg_done_i;
        cfg.err      = cfg_err_i;
        cfg.load_off = load_off_i;
        src.button   = button_level;
        src.chip_req = chip_req_i;
    end

    sysrst_fsm #(
        .POR_CYCLES  (POR_CYCLES),
        .CFG_TIMEOUT (CFG_TIMEOUT),
        .MIN_PULSE   (MIN_PULSE)
    ) u_fsm (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .cfg_i   (cfg),
        .src_i   (src),
        .rst_o   (sys_rst_o),
        .fault_o (cfg_fault_o)
    );

    // R1: one clock after power-on is seen, reset is on and the fault is clear
    a_r1_por_state: assert property (@(posedge clk_i) disable iff (por_i)
        $past(por_i) |-> (sys_rst_o && !cfg_fault_o));

endmodule

// File: tb/sysrst_gate_tb.sv
`timescale 1ns/1ps
module sysrst_gate_tb_top;
    localparam int POR = 16;
    localparam int TO  = 40;
    localparam int MIN = 12;
    localparam int DEB = 8;
    localparam int WIN = 80;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic done = 1'b0, err = 1'b0, strap = 1'b0, btn = 1'b0, req = 1'b0;
    logic sys_rst, fault;
    int   n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    sysrst_gate #(
        .POR_CYCLES(POR), .CFG_TIMEOUT(TO), .MIN_PULSE(MIN),
        .DEB_CYCLES(DEB), .SYNC_STAGES(2)
    ) dut_i (
        .clk_i(clk), .por_i(por), .cfg_done_i(done), .cfg_err_i(err),
        .load_off_i(strap), .button_i(btn), .chip_req_i(req),
        .sys_rst_o(sys_rst), .cfg_fault_o(fault)
    );

    // Boot vectors: edge numbers counted from the first edge with power-on low, 0 = never
    typedef struct packed {
        logic       strap;
        logic [7:0] done_at;
        logic [7:0] err_at;
        logic [7:0] rel_at;
        logic [7:0] fault_at;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b1, 8'd0,  8'd0,  8'd16, 8'd0 },  // R2/R6 strap, nothing else
        '{1'b1, 8'd0,  8'd3,  8'd16, 8'd0 },  // R6 error ignored
        '{1'b0, 8'd1,  8'd0,  8'd17, 8'd0 },  // R2/R3 done early, honoured at POR+1
        '{1'b0, 8'd25, 8'd0,  8'd25, 8'd0 },  // R3 done mid-wait
        '{1'b0, 8'd16, 8'd0,  8'd17, 8'd0 },  // R3 done at last delay edge
        '{1'b0, 8'd22, 8'd20, 8'd0,  8'd20},  // R4 error then done
        '{1'b0, 8'd20, 8'd20, 8'd0,  8'd20},  // R4 error wins same edge
        '{1'b0, 8'd0,  8'd0,  8'd0,  8'd56},  // R5 timeout
        '{1'b0, 8'd56, 8'd0,  8'd56, 8'd0 },  // R5 done at final edge
        '{1'b0, 8'd57, 8'd0,  8'd0,  8'd56},  // R5 done too late
        '{1'b0, 8'd0,  8'd10, 8'd0,  8'd17}   // R4 error held from delay phase
    };

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_on(input logic s);
        @(negedge clk);
        por = 1'b1; done = 1'b0; err = 1'b0; btn = 1'b0; req = 1'b0; strap = s;
        repeat (3) tick();
    endtask

    // Count high cycles of reset over n sampled cycles
    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (sys_rst) highs++;
        end
    endtask

    initial begin
        int rel, flt, highs;
        string tag;

        // Vector table walk
        for (int v = 0; v < 11; v++) begin
            power_on(VECS[v].strap);
            por = 1'b0;
            rel = 0; flt = 0;
            for (int e = 1; e <= WIN; e++) begin
                done = (VECS[v].done_at != 0) && (e >= int'(VECS[v].done_at));
                err  = (VECS[v].err_at  != 0) && (e >= int'(VECS[v].err_at));
                tick();
                if (rel == 0 && !sys_rst) rel = e;
                if (flt == 0 && fault)    flt = e;
            end
            tag = VECS[v].strap ? "R6 boot" : (VECS[v].fault_at != 0 ? "R4/R5 boot" : "R3 boot");
            check({tag, " release edge"}, rel, int'(VECS[v].rel_at));
            check({tag, " fault edge"},   flt, int'(VECS[v].fault_at));
        end

        // R1: power-on clears the parked fault and asserts reset
        @(negedge clk);
        por = 1'b1; done = 1'b0; err = 1'b0;
        tick();
        check("R1 reset during power-on", int'(sys_rst), 1);
        check("R1 fault cleared by power-on", int'(fault), 0);

        // R7: sources during delay and wait are ignored
        power_on(1'b0);
        por = 1'b0;
        rel = 0;
        for (int e = 1; e <= 45; e++) begin
            btn  = (e >= 2 && e <= 20);
            req  = (e >= 5 && e <= 8);
            done = (e >= 45);
            tick();
            if (rel == 0 && !sys_rst) rel = e;
        end
        check("R7 release unaffected by sources", rel, 45);
        count_high(30, highs);
        check("R7 no late pulse", highs, 0);

        // R8: single-cycle chipset request
        req = 1'b1;
        tick();
        check("R8 reset rises after request edge", int'(sys_rst), 1);
        req = 1'b0;
        highs = 1;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (sys_rst) highs++;
        end
        check("R8 pulse width", highs, MIN);

        // R9: debounced press timing
        btn = 1'b1;
        repeat (DEB + 2) tick();
        check("R9 no reset before debounce", int'(sys_rst), 0);
        tick();
        check("R9 reset after debounce", int'(sys_rst), 1);
        btn = 1'b0;
        repeat (40) tick();
        check("R9 released after press", int'(sys_rst), 0);

        // R9: short glitch ignored
        btn = 1'b1;
        repeat (3) tick();
        btn = 1'b0;
        count_high(30, highs);
        check("R9 glitch ignored", highs, 0);

        // R10: held request stretches reset
        highs = 0;
        req = 1'b1;
        for (int e = 1; e <= 30; e++) begin
            tick();
            if (sys_rst) highs++;
        end
        check("R10 reset held while requested", highs, 30);
        req = 1'b0;
        tick();
        check("R10 release one edge after request drops", int'(sys_rst), 0);

        // R11: back in running state, new request handled the same way
        check("R11 fault stays clear", int'(fault), 0);
        req = 1'b1;
        tick();
        req = 1'b0;
        highs = 1;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (sys_rst) highs++;
        end
        check("R11 second pulse width", highs, MIN);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule